// File: doc/BRIEF.md
# Indexed Register Access Port

This block lets a host reach a 256-entry, 8-bit register space through a window of only eight byte offsets. The host first places a register number in an internal index latch. It then moves data through one of two data ports. The plain port leaves the index where it is. The stepping port advances the index after the access, so a run of neighbouring registers can be read or written without reloading the index. A further offset reads back the current index. Another offset pulses a timed hardware reset towards the attached controller.

Each host access lasts one clock cycle, marked by `host_rd` or `host_wr`. A data-port access produces exactly one single-cycle strobe on the back-end bus in that same cycle, with the address taken from the index latch. Read data is captured into `host_rdata` at the clock edge that ends the read cycle. It holds there until the next read. The controller behind the back-end bus is not part of this block.

Top module: `idx_reg_bridge`

## Requirements
- R1: A write to offset 1 loads the index latch with `host_wdata` at the end of that cycle, and the latch drives `be_addr`. Block reset clears the index to 0x00, clears `host_rdata` to 0x00 and deasserts `ctl_rst`.
- R2: A read of offset 2 raises `be_rd` for that one cycle and returns `be_rdata` on `host_rdata` from the next cycle onward. The index is not changed.
- R3: A read of offset 3 behaves like offset 2, and the index then advances by one. The index wraps from 0xFF to 0x00, so consecutive reads fetch consecutive registers.
- R4: A read of offset 5 returns the current index on `host_rdata` and causes no back-end strobe.
- R5: A write to offset 6 raises `be_wr` for one cycle, with `be_addr` set to the index and `be_wdata` set to `host_wdata`. The index is not changed.
- R6: A write to offset 7 behaves like offset 6, and the index then advances by one, wrapping from 0xFF to 0x00.
- R7: A write to offset 0 asserts `ctl_rst` from the next cycle for exactly `RST_CYCLES` cycles. A further offset-0 write during that time restarts the full count.
- R8: While `ctl_rst` is high, no back-end strobe is issued. Data-port accesses are dropped: reads of offsets 2 and 3 return 0x00, and the index does not advance.
- R9: Reads of offsets 0, 4, 6 and 7 return 0x00. Writes to offsets 2, 3, 4 and 5 change neither the index nor the back-end registers, and produce no strobe.
- R10: When `host_rd` and `host_wr` are both high in one cycle, only the write takes place. `host_rdata` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the block |
| host_off | input | 3 | Host window offset |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| be_addr | output | 8 | Back-end register address (index latch) |
| be_wdata | output | 8 | Back-end write data |
| be_rdata | input | 8 | Back-end read data, combinational from `be_addr` |
| be_rd | output | 1 | Back-end read strobe |
| be_wr | output | 1 | Back-end write strobe |
| ctl_rst | output | 1 | Reset to the attached controller, active high |

## Verification
The following rules are checked on every cycle:
- The index follows each loading write and each stepping access, and stays put on plain and ignored accesses.
- Strobes never appear while the controller reset is high.
- That reset starts right after an offset-0 write and never outlasts its window.

Only the directed scenarios can show some of the behaviour:
- Which register a read actually returns, and the data that lands in the register file.
- That the reset lasts exactly its length, including a restart part-way through.
- The wrap of a stepping run across 0xFF.
- That a read colliding with a write leaves the read data untouched.

// File: rtl/idx_reg_bridge.sv
module idx_reg_bridge #(
  parameter int RST_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] host_off,
  input  logic       host_rd,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic [7:0] be_addr,
  output logic [7:0] be_wdata,
  input  logic [7:0] be_rdata,
  output logic       be_rd,
  output logic       be_wr,
  output logic       ctl_rst
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [7:0]    idx;
  logic [CW-1:0] rst_cnt;
  logic          busy, rd, data_rd, data_wr, step;

  assign busy     = (rst_cnt != '0);
  assign ctl_rst  = busy;
  assign rd       = host_rd & ~host_wr;
  assign data_rd  = rd & (host_off[2:1] == 2'b01);
  assign data_wr  = host_wr & (host_off[2:1] == 2'b11);
  assign be_rd    = data_rd & ~busy;
  assign be_wr    = data_wr & ~busy;
  assign be_addr  = idx;
  assign be_wdata = host_wdata;
  assign step     = (be_rd | be_wr) & host_off[0];

  always_ff @(posedge clk) begin
    if (!rst_n)
      idx <= 8'h00;
    else if (host_wr && host_off == 3'd1)
      idx <= host_wdata;
    else if (step)
      idx <= idx + 8'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rst_cnt <= '0;
    else if (host_wr && host_off == 3'd0)
      rst_cnt <= CW'(RST_CYCLES);
    else if (busy)
      rst_cnt <= rst_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      host_rdata <= 8'h00;
    else if (rd) begin
      if (data_rd)
        host_rdata <= busy ? 8'h00 : be_rdata;
      else if (host_off == 3'd5)
        host_rdata <= idx;
      else
        host_rdata <= 8'h00;
    end
  end
endmodule

// File: rtl/idx_reg_bridge_chk.sv
module idx_reg_bridge_chk #(
  parameter int RST_CYCLES = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] host_off,
  input logic       host_rd,
  input logic       host_wr,
  input logic [7:0] host_wdata,
  input logic [7:0] host_rdata,
  input logic [7:0] be_addr,
  input logic       be_rd,
  input logic       be_wr,
  input logic       ctl_rst
);
  logic [31:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n)
      run <= 32'd0;
    else if (host_wr && host_off == 3'd0)
      run <= 32'd0;
    else if (ctl_rst)
      run <= run + 32'd1;
    else
      run <= 32'd0;
  end

  assert_index_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_off == 3'd1) |=> (be_addr == $past(host_wdata)));

  assert_plain_read_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && host_off == 3'd2) |=> $stable(be_addr));

  assert_read_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (be_rd && host_off == 3'd3) |=> (be_addr == $past(be_addr) + 8'd1));

  assert_index_readback_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && host_off == 3'd5) |=> (host_rdata == $past(be_addr)));

  assert_plain_write_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_off == 3'd6) |=> $stable(be_addr));

  assert_write_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (be_wr && host_off == 3'd7) |=> (be_addr == $past(be_addr) + 8'd1));

  assert_reset_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_off == 3'd0) |=> ctl_rst);

  assert_reset_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rst |-> (run < RST_CYCLES));

  assert_quiet_in_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rst |-> (!be_rd && !be_wr));

  assert_ignored_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && (host_off == 3'd2 || host_off == 3'd3 || host_off == 3'd4 || host_off == 3'd5))
      |=> $stable(be_addr));

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_wr) |-> !be_rd);
endmodule

bind idx_reg_bridge idx_reg_bridge_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_off(host_off), .host_rd(host_rd),
  .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .be_addr(be_addr), .be_rd(be_rd), .be_wr(be_wr), .ctl_rst(ctl_rst)
);

// File: tb/test_idx_reg_bridge.sv
module test_idx_reg_bridge;
  localparam int RST_CYCLES = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] host_off = 3'd0;
  logic       host_rd = 1'b0;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata, be_addr, be_wdata, be_rdata;
  logic       be_rd, be_wr, ctl_rst;

  logic [7:0] mem [0:255];
  int n_rd = 0, n_wr = 0;
  int checks = 0, errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  idx_reg_bridge #(.RST_CYCLES(RST_CYCLES)) i_idx_reg_bridge (
    .clk(clk), .rst_n(rst_n), .host_off(host_off), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .be_addr(be_addr), .be_wdata(be_wdata), .be_rdata(be_rdata),
    .be_rd(be_rd), .be_wr(be_wr), .ctl_rst(ctl_rst)
  );

  assign be_rdata = mem[be_addr];

  always @(posedge clk) begin
    if (be_wr) mem[be_addr] <= be_wdata;
    if (be_rd) n_rd <= n_rd + 1;
    if (be_wr) n_wr <= n_wr + 1;
  end

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      finish_sim();
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic host_write(logic [2:0] off, logic [7:0] d);
    @(negedge clk); host_off = off; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic host_read(logic [2:0] off, output logic [7:0] d);
    @(negedge clk); host_off = off; host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0; d = host_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 rdata after reset", host_rdata, 8'h00);
    check("R1 ctl_rst after reset", ctl_rst, 0);
    check("R1 index after reset", be_addr, 8'h00);
    host_read(3'd5, d);
    check("R1 R4 index readback after reset", d, 8'h00);
  endtask

  task automatic t_index();
    logic [7:0] d;
    host_write(3'd1, 8'h3C);
    host_read(3'd5, d);
    check("R1 R4 index load", d, 8'h3C);
    host_write(3'd1, 8'hC3);
    host_read(3'd5, d);
    check("R4 index reload", d, 8'hC3);
  endtask

  task automatic t_plain_read();
    logic [7:0] d;
    int r0;
    mem[8'h3C] = 8'hA5;
    host_write(3'd1, 8'h3C);
    r0 = n_rd;
    host_read(3'd2, d);
    check("R2 plain read data", d, 8'hA5);
    host_read(3'd2, d);
    check("R2 plain read again", d, 8'hA5);
    check("R2 one strobe per read", n_rd - r0, 2);
    host_read(3'd5, d);
    check("R2 index unchanged", d, 8'h3C);
  endtask

  task automatic t_auto_read();
    logic [7:0] d;
    mem[8'hFE] = 8'h11; mem[8'hFF] = 8'h22; mem[8'h00] = 8'h33;
    host_write(3'd1, 8'hFE);
    host_read(3'd3, d); check("R3 step read 0xFE", d, 8'h11);
    host_read(3'd3, d); check("R3 step read 0xFF", d, 8'h22);
    host_read(3'd3, d); check("R3 step read wrap 0x00", d, 8'h33);
    host_read(3'd5, d); check("R3 index after wrap", d, 8'h01);
  endtask

  task automatic t_writes();
    logic [7:0] d;
    host_write(3'd1, 8'h40);
    host_write(3'd6, 8'h77);
    check("R5 plain write data", mem[8'h40], 8'h77);
    host_read(3'd5, d); check("R5 index unchanged", d, 8'h40);
    host_write(3'd1, 8'hFF);
    host_write(3'd7, 8'hA1);
    host_write(3'd7, 8'hA2);
    host_write(3'd7, 8'hA3);
    check("R6 step write 0xFF", mem[8'hFF], 8'hA1);
    check("R6 step write wrap 0x00", mem[8'h00], 8'hA2);
    check("R6 step write 0x01", mem[8'h01], 8'hA3);
    host_read(3'd5, d); check("R6 index after run", d, 8'h02);
  endtask

  task automatic t_unused();
    logic [7:0] d;
    int w0;
    host_write(3'd1, 8'h50);
    mem[8'h50] = 8'h99;
    host_read(3'd2, d);
    host_read(3'd0, d); check("R9 read off 0", d, 8'h00);
    host_read(3'd2, d);
    host_read(3'd4, d); check("R9 read off 4", d, 8'h00);
    host_read(3'd2, d);
    host_read(3'd6, d); check("R9 read off 6", d, 8'h00);
    host_read(3'd2, d);
    host_read(3'd7, d); check("R9 read off 7", d, 8'h00);
    w0 = n_wr;
    for (int o = 2; o <= 5; o++) host_write(3'(o), 8'hEE);
    check("R9 no write strobe", n_wr - w0, 0);
    check("R9 register untouched", mem[8'h50], 8'h99);
    host_read(3'd5, d); check("R9 index unchanged", d, 8'h50);
  endtask

  task automatic t_ctl_reset();
    logic [7:0] d;
    int n, r0, w0;
    host_write(3'd0, 8'h00);
    n = 0;
    while (ctl_rst && n < 1000) begin n++; @(negedge clk); end
    check("R7 reset length", n, RST_CYCLES);
    host_write(3'd1, 8'h60);
    mem[8'h60] = 8'h5D;
    host_write(3'd0, 8'h00);
    r0 = n_rd; w0 = n_wr;
    host_read(3'd3, d);  check("R8 read during reset", d, 8'h00);
    host_write(3'd7, 8'h12);
    check("R8 no strobes in reset", (n_rd - r0) + (n_wr - w0), 0);
    check("R8 register untouched", mem[8'h60], 8'h5D);
    host_read(3'd5, d);  check("R8 index not stepped", d, 8'h60);
    host_write(3'd0, 8'h00);
    n = 0;
    while (ctl_rst && n < 1000) begin n++; @(negedge clk); end
    check("R7 restart length", n, RST_CYCLES);
  endtask

  task automatic t_both();
    logic [7:0] d;
    int r0;
    host_write(3'd1, 8'h70);
    mem[8'h70] = 8'h4B;
    host_read(3'd2, d);
    r0 = n_rd;
    @(negedge clk); host_off = 3'd6; host_wdata = 8'hB4; host_rd = 1'b1; host_wr = 1'b1;
    @(negedge clk); host_rd = 1'b0; host_wr = 1'b0;
    check("R10 rdata kept", host_rdata, 8'h4B);
    check("R10 no read strobe", n_rd - r0, 0);
    check("R10 write done", mem[8'h70], 8'hB4);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_index();
    t_plain_read();
    t_auto_read();
    t_writes();
    t_unused();
    t_ctl_reset();
    t_both();
    finish_sim();
  end
endmodule